// File: doc/BRIEF.md
# Guest System-Register Write Unit

This block executes the move-to-guest-system-register instruction. It decodes a 32-bit instruction word and takes the 64-bit value of the source general register as its operand. It checks whether coprocessor access and hardware virtualization are enabled. It then formats the operand for the addressed guest register and writes the result into a small guest register file that it owns. The destination is named by the register number and the select field taken together. Some entries are full guest copies of 64 or 32 bits. Two are page-entry-low registers, whose top bits are relocated. One is a shared register, of which the guest may change only some bits. One is a free-running cycle counter that cannot be written. Every other address is unimplemented.

The issue side presents an instruction with `in_valid`. The block never applies back-pressure: there is no ready signal, and a new instruction may arrive in every cycle. The write port and the exception outputs are registered. They show the result one clock after the strobe, and the register file commits on the following edge. The combinational read port `rd_idx`/`rd_data` lets the surrounding core, or a bench, observe the file's contents.

Top module: `gsr_write_unit`

## Requirements
- R1: Only the exact word pattern is recognised: bits 31:26 = 010000, bits 25:21 = 00011, bits 10:8 = 010 and bits 7:3 = 00000. The fields are source register rt at bits 20:16, register number rd at bits 15:11 and select sel at bits 2:0. Any other word causes no write and no exception.
- R2: A recognised instruction with `in_cop_en` = 0 raises `exc_cpu`, causes no write and takes priority over every other check, whatever the value of `in_virt_en`.
- R3: A recognised instruction with `in_cop_en` = 1 and `in_virt_en` = 0 raises `exc_ri` and causes no write.
- R4: `wr_en`, `exc_cpu` and `exc_ri` appear in the cycle after the strobe, and at most one of them is high in any cycle. `wr_idx` is {rd, sel} (8 bits).
- R5: For the page-entry-low registers at {rd,sel} = 0x10 (rd 2, sel 0) and 0x18 (rd 3, sel 0), the written data has bits 29:0 = operand 29:0, bit 63 = operand 31 and bit 62 = operand 30. Bits 61:30 are zero.
- R6: The 64-bit replicated register at 0x20 (rd 4, sel 0) receives all 64 operand bits unchanged.
- R7: The 32-bit registers at 0x60 (rd 12, sel 0) and 0x81 (rd 16, sel 1) receive operand bits 31:0. Bits 63:32 are written as zero.
- R8: The shared register at 0x98 (rd 19, sel 0) is always written, and only the bits set in its writable mask (default 0x0000_0000_4000_0FF8) change. Its new value is (old & ~mask) | (data & mask).
- R9: The counter at 0x48 (rd 9, sel 0) is read-only. It resets to 0 and increases by one each clock. A write to it raises no `wr_en`, no exception and does not disturb its count.
- R10: A write to any unimplemented address, including an unused select of an implemented register number such as 0x80, is dropped. It raises no `wr_en`, no exception and leaves every register unchanged. Unimplemented addresses read as 0.
- R11: After reset, all outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe, one instruction per high cycle |
| in_instr | input | 32 | Instruction word |
| in_operand | input | 64 | Value of general register rt |
| in_cop_en | input | 1 | Coprocessor access enabled |
| in_virt_en | input | 1 | Virtualization hardware present |
| rd_idx | input | 8 | Read address {rd, sel} |
| wr_en | output | 1 | Write to guest file in this cycle |
| wr_idx | output | 8 | Destination {rd, sel} |
| wr_src | output | 5 | Source register number rt of the instruction |
| wr_data | output | 64 | Formatted write data |
| exc_cpu | output | 1 | Coprocessor-unusable exception |
| exc_ri | output | 1 | Reserved-instruction exception |
| rd_data | output | 64 | Contents of the register at `rd_idx` |

## Verification
Each destination class receives operands that separate the formatting rules. All-ones separates zeroing from relocation on the page-entry registers. Words with only bit 31 or only bit 30 set show that each lands on its own top bit. A distinct 64-bit pattern sent to the full, 32-bit and shared registers shows truncation and masking against an unchanged copy. The exception paths are driven with both enable flags low and with only virtualization low, which separates the two checks and their priority. Corrupted fixed fields show that decode is exact. A pair of writes to the same register number with different select values shows that select takes part in addressing.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
  localparam int DATA_W    = 64;
  localparam int RD_W      = 5;
  localparam int SEL_W     = 3;
  localparam int IDX_W     = RD_W + SEL_W;
  localparam int NUM_SLOTS = 7;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_PAGE   = 3'd1,
    K_R64    = 3'd2,
    K_R32    = 3'd3,
    K_SHARED = 3'd4,
    K_RO     = 3'd5
  } kind_t;

  // Address {rd, sel} of each implemented slot.
  function automatic logic [IDX_W-1:0] slot_addr(input int s);
    case (s)
      0:       return {5'd2,  3'd0};
      1:       return {5'd3,  3'd0};
      2:       return {5'd9,  3'd0};
      3:       return {5'd4,  3'd0};
      4:       return {5'd12, 3'd0};
      5:       return {5'd19, 3'd0};
      6:       return {5'd16, 3'd1};
      default: return '1;
    endcase
  endfunction

  function automatic kind_t slot_kind(input int s);
    case (s)
      0, 1:    return K_PAGE;
      2:       return K_RO;
      3:       return K_R64;
      4, 6:    return K_R32;
      5:       return K_SHARED;
      default: return K_NONE;
    endcase
  endfunction

  function automatic kind_t idx_kind(input logic [IDX_W-1:0] idx);
    kind_t k;
    k = K_NONE;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_addr(s) == idx) k = slot_kind(s);
    end
    return k;
  endfunction

  function automatic logic kind_writable(input kind_t k);
    return (k == K_PAGE) || (k == K_R64) || (k == K_R32) || (k == K_SHARED);
  endfunction
endpackage

// File: rtl/gsr_decode.sv
module gsr_decode
  import gsr_pkg::*;
(
  input  logic [31:0]      instr,
  output logic             hit,
  output logic [4:0]       rt,
  output logic [RD_W-1:0]  rd,
  output logic [SEL_W-1:0] sel
);
  localparam logic [5:0] OPC    = 6'b010000;
  localparam logic [4:0] SUBOP  = 5'b00011;
  localparam logic [2:0] FIXA   = 3'b010;
  localparam logic [4:0] FIXB   = 5'b00000;

  always_comb begin
    hit = (instr[31:26] == OPC) && (instr[25:21] == SUBOP) &&
          (instr[10:8] == FIXA) && (instr[7:3] == FIXB);
    rt  = instr[20:16];
    rd  = instr[15:11];
    sel = instr[2:0];
  end
endmodule

// File: rtl/gsr_format.sv
module gsr_format
  import gsr_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  kind_t             kind,
  output logic [DATA_W-1:0] data
);
  localparam int HALF = DATA_W / 2;

  always_comb begin
    unique case (kind)
      K_PAGE: data = {operand[31], operand[30], {(DATA_W-32){1'b0}}, operand[29:0]};
      K_R32:  data = {{HALF{1'b0}}, operand[HALF-1:0]};
      default: data = operand;
    endcase
  end
endmodule

// File: rtl/gsr_regfile.sv
module gsr_regfile
  import gsr_pkg::*;
#(
  parameter logic [DATA_W-1:0] SHARED_MASK = 64'h0000_0000_4000_0FF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam kind_t K = slot_kind(s);
    localparam logic [IDX_W-1:0] A = slot_addr(s);
    if (K == K_RO) begin : g_cnt
      always_ff @(posedge clk) begin
        if (!rst_n) slot_q[s] <= '0;
        else        slot_q[s] <= slot_q[s] + 1'b1;
      end
    end else begin : g_rw
      localparam logic [DATA_W-1:0] M = (K == K_SHARED) ? SHARED_MASK : '1;
      always_ff @(posedge clk) begin
        if (!rst_n)                 slot_q[s] <= '0;
        else if (we && widx == A)   slot_q[s] <= (slot_q[s] & ~M) | (wdata & M);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_addr(s) == ridx) rdata = slot_q[s];
    end
  end
endmodule

// File: rtl/gsr_write_unit.sv
module gsr_write_unit
  import gsr_pkg::*;
#(
  parameter logic [63:0] SHARED_MASK = 64'h0000_0000_4000_0FF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  input  logic [63:0] in_operand,
  input  logic        in_cop_en,
  input  logic        in_virt_en,
  input  logic [7:0]  rd_idx,
  output logic        wr_en,
  output logic [7:0]  wr_idx,
  output logic [4:0]  wr_src,
  output logic [63:0] wr_data,
  output logic        exc_cpu,
  output logic        exc_ri,
  output logic [63:0] rd_data
);
  logic              dec_hit;
  logic [4:0]        dec_rt;
  logic [RD_W-1:0]   dec_rd;
  logic [SEL_W-1:0]  dec_sel;
  logic [IDX_W-1:0]  dec_idx;
  kind_t             dec_kind;
  logic [DATA_W-1:0] fmt_data;

  gsr_decode u_dec (
    .instr (in_instr),
    .hit   (dec_hit),
    .rt    (dec_rt),
    .rd    (dec_rd),
    .sel   (dec_sel)
  );

  assign dec_idx  = {dec_rd, dec_sel};
  assign dec_kind = idx_kind(dec_idx);

  gsr_format u_fmt (
    .operand (in_operand),
    .kind    (dec_kind),
    .data    (fmt_data)
  );

  logic take, cpu_n, ri_n, go_n;
  always_comb begin
    take  = in_valid && dec_hit;
    cpu_n = take && !in_cop_en;
    ri_n  = take && in_cop_en && !in_virt_en;
    go_n  = take && in_cop_en && in_virt_en && kind_writable(dec_kind);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      exc_cpu <= 1'b0;
      exc_ri  <= 1'b0;
      wr_idx  <= '0;
      wr_src  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= go_n;
      exc_cpu <= cpu_n;
      exc_ri  <= ri_n;
      if (take) begin
        wr_idx  <= dec_idx;
        wr_src  <= dec_rt;
        wr_data <= fmt_data;
      end
    end
  end

  gsr_regfile #(.SHARED_MASK(SHARED_MASK)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .ridx  (rd_idx),
    .rdata (rd_data)
  );
endmodule

// File: rtl/gsr_write_chk.sv
module gsr_write_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic [63:0] in_operand,
  input logic        in_cop_en,
  input logic        in_virt_en,
  input logic        wr_en,
  input logic [7:0]  wr_idx,
  input logic [63:0] wr_data,
  input logic        exc_cpu,
  input logic        exc_ri
);
  logic rec;
  logic [7:0] cidx;
  assign rec  = in_valid && in_instr[31:21] == 11'b010000_00011 && in_instr[10:3] == 8'b010_00000;
  assign cidx = {in_instr[15:11], in_instr[2:0]};

  p_one_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, exc_cpu, exc_ri}));
  p_cpu_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec && !in_cop_en |=> exc_cpu && !wr_en && !exc_ri);
  p_ri_raised_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec && in_cop_en && !in_virt_en |=> exc_ri && !wr_en);
  p_no_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && rec) |=> !wr_en && !exc_cpu && !exc_ri);
  p_page_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_idx == 8'h10 || wr_idx == 8'h18) |-> wr_data[61:30] == 32'h0);
  p_full_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec && in_cop_en && in_virt_en && cidx == 8'h20 |=> wr_en && wr_data == $past(in_operand));
  p_low_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_idx == 8'h60 || wr_idx == 8'h81) |-> wr_data[63:32] == 32'h0);
  p_ro_counter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == 8'h48));
  p_unimpl_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec && in_cop_en && in_virt_en && cidx == 8'h80 |=> !wr_en && !exc_cpu && !exc_ri);
endmodule

bind gsr_write_unit gsr_write_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_instr   (in_instr),
  .in_operand (in_operand),
  .in_cop_en  (in_cop_en),
  .in_virt_en (in_virt_en),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .exc_cpu    (exc_cpu),
  .exc_ri     (exc_ri)
);

// File: tb/gsr_write_unit_tb_top.sv
`timescale 1ns/1ps
module gsr_write_unit_tb_top;
  localparam logic [63:0] MASK = 64'h0000_0000_4000_0FF8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [63:0] in_operand;
  logic        in_cop_en, in_virt_en;
  logic [7:0]  rd_idx;
  logic        wr_en, exc_cpu, exc_ri;
  logic [7:0]  wr_idx;
  logic [4:0]  wr_src;
  logic [63:0] wr_data, rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Sampled results of the last issue() call.
  logic        s_en, s_cpu, s_ri;
  logic [7:0]  s_idx;
  logic [63:0] s_data, s_rd;

  always #2.5 clk = ~clk;

  gsr_write_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_operand(in_operand), .in_cop_en(in_cop_en), .in_virt_en(in_virt_en),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(wr_src),
    .wr_data(wr_data), .exc_cpu(exc_cpu), .exc_ri(exc_ri), .rd_data(rd_data)
  );

  function automatic logic [31:0] mk(input logic [4:0] rd, input logic [2:0] sel);
    return {6'b010000, 5'b00011, 5'd7, rd, 3'b010, 5'b00000, sel};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; drives one instruction, samples outputs
  // one edge later, then reads address ridx after the commit edge.
  task automatic issue(input logic [31:0] w, input logic [63:0] op, input bit cop,
                       input bit virt, input logic [7:0] ridx);
    in_valid = 1'b1; in_instr = w; in_operand = op; in_cop_en = cop; in_virt_en = virt;
    @(negedge clk); #0.5;
    s_en = wr_en; s_cpu = exc_cpu; s_ri = exc_ri; s_idx = wr_idx; s_data = wr_data;
    in_valid = 1'b0; in_instr = '0; in_operand = '0;
    @(negedge clk);
    rd_idx = ridx; #0.5;
    s_rd = rd_data;
  endtask

  task automatic t_reset;
    chk(!wr_en && !exc_cpu && !exc_ri, "R11 outputs", {61'b0, wr_en, exc_cpu, exc_ri}, 64'h0);
    rd_idx = 8'h20; #0.5;
    chk(rd_data == 64'h0, "R11 context", rd_data, 64'h0);
    rd_idx = 8'h98; #0.5;
    chk(rd_data == 64'h0, "R11 shared", rd_data, 64'h0);
  endtask

  task automatic t_page;
    issue(mk(5'd2, 3'd0), 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 8'h10);
    chk(s_en && s_idx == 8'h10, "R5 write strobe", {55'b0, s_en, s_idx}, {55'b0, 1'b1, 8'h10});
    chk(s_data == 64'hC000_0000_3FFF_FFFF, "R5 all ones data", s_data, 64'hC000_0000_3FFF_FFFF);
    chk(s_rd == 64'hC000_0000_3FFF_FFFF, "R5 all ones readback", s_rd, 64'hC000_0000_3FFF_FFFF);
    issue(mk(5'd2, 3'd0), 64'h0000_0000_8000_0001, 1, 1, 8'h10);
    chk(s_rd == 64'h8000_0000_0000_0001, "R5 bit31 to 63", s_rd, 64'h8000_0000_0000_0001);
    issue(mk(5'd3, 3'd0), 64'h1234_5678_7FFF_FFFF, 1, 1, 8'h18);
    chk(s_rd == 64'h4000_0000_3FFF_FFFF, "R5 bit30 to 62 on second", s_rd, 64'h4000_0000_3FFF_FFFF);
  endtask

  task automatic t_full;
    issue(mk(5'd4, 3'd0), 64'hDEAD_BEEF_0123_4567, 1, 1, 8'h20);
    chk(s_data == 64'hDEAD_BEEF_0123_4567 && s_src_ok(), "R6 data", s_data, 64'hDEAD_BEEF_0123_4567);
    chk(s_rd == 64'hDEAD_BEEF_0123_4567, "R6 readback", s_rd, 64'hDEAD_BEEF_0123_4567);
  endtask

  function automatic bit s_src_ok();
    return wr_src == 5'd7;
  endfunction

  task automatic t_half;
    issue(mk(5'd12, 3'd0), 64'hDEAD_BEEF_0123_4567, 1, 1, 8'h60);
    chk(s_rd == 64'h0000_0000_0123_4567, "R7 low half", s_rd, 64'h0000_0000_0123_4567);
    issue(mk(5'd16, 3'd1), 64'hFFFF_FFFF_89AB_CDEF, 1, 1, 8'h81);
    chk(s_rd == 64'h0000_0000_89AB_CDEF, "R7 sel1 reg", s_rd, 64'h0000_0000_89AB_CDEF);
  endtask

  task automatic t_shared;
    logic [63:0] old, exp;
    issue(mk(5'd19, 3'd0), 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 8'h98);
    chk(s_en, "R8 always written", {63'b0, s_en}, 64'h1);
    chk(s_rd == MASK, "R8 ones masked", s_rd, MASK);
    old = s_rd;
    issue(mk(5'd19, 3'd0), 64'h0123_4567_89AB_CDEF, 1, 1, 8'h98);
    exp = (old & ~MASK) | (64'h0123_4567_89AB_CDEF & MASK);
    chk(s_rd == exp, "R8 merge", s_rd, exp);
  endtask

  task automatic t_counter;
    logic [63:0] v1;
    rd_idx = 8'h48; #0.5;
    v1 = rd_data;
    chk(v1 != 64'h0, "R9 counting", v1, 64'h1);
    issue(mk(5'd9, 3'd0), 64'h0, 1, 1, 8'h48);
    chk(!s_en && !s_cpu && !s_ri, "R9 no strobe", {61'b0, s_en, s_cpu, s_ri}, 64'h0);
    chk(s_rd == v1 + 64'd2, "R9 count kept", s_rd, v1 + 64'd2);
  endtask

  task automatic t_unimpl;
    issue(mk(5'd16, 3'd1), 64'h0000_0000_5555_AAAA, 1, 1, 8'h81);
    issue(mk(5'd16, 3'd0), 64'h0000_0000_1111_2222, 1, 1, 8'h81);
    chk(!s_en && !s_cpu && !s_ri, "R10 no strobe", {61'b0, s_en, s_cpu, s_ri}, 64'h0);
    chk(s_rd == 64'h5555_AAAA, "R10 neighbour sel kept", s_rd, 64'h5555_AAAA);
    issue(mk(5'd5, 3'd0), 64'hFFFF, 1, 1, 8'h28);
    chk(!s_en && s_rd == 64'h0, "R10 reads zero", s_rd, 64'h0);
  endtask

  task automatic t_cpu;
    issue(mk(5'd4, 3'd0), 64'h1111_1111_1111_1111, 0, 0, 8'h20);
    chk(s_cpu && !s_ri && !s_en, "R2 cpu only", {61'b0, s_en, s_cpu, s_ri}, 64'h2);
    chk(s_rd == 64'hDEAD_BEEF_0123_4567, "R2 no write", s_rd, 64'hDEAD_BEEF_0123_4567);
    issue(mk(5'd4, 3'd0), 64'h1111_1111_1111_1111, 0, 1, 8'h20);
    chk(s_cpu && !s_ri && !s_en, "R2 with virt", {61'b0, s_en, s_cpu, s_ri}, 64'h2);
  endtask

  task automatic t_ri;
    issue(mk(5'd4, 3'd0), 64'h2222_2222_2222_2222, 1, 0, 8'h20);
    chk(s_ri && !s_cpu && !s_en, "R3 ri only", {61'b0, s_en, s_cpu, s_ri}, 64'h1);
    chk(s_rd == 64'hDEAD_BEEF_0123_4567, "R3 no write", s_rd, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_decode;
    issue(mk(5'd4, 3'd0) ^ 32'h0000_0100, 64'h3, 1, 1, 8'h20);
    chk(!s_en && !s_cpu && !s_ri, "R1 fixed field", {61'b0, s_en, s_cpu, s_ri}, 64'h0);
    issue(mk(5'd4, 3'd0) ^ 32'h0020_0000, 64'h3, 0, 1, 8'h20);
    chk(!s_en && !s_cpu && !s_ri, "R1 sub-op", {61'b0, s_en, s_cpu, s_ri}, 64'h0);
    issue(mk(5'd4, 3'd0) ^ 32'h0000_0008, 64'h3, 1, 1, 8'h20);
    chk(s_rd == 64'hDEAD_BEEF_0123_4567, "R1 low fixed bits", s_rd, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_timing;
    in_valid = 1'b1; in_instr = mk(5'd4, 3'd0); in_operand = 64'h77; in_cop_en = 1; in_virt_en = 1;
    #0.5;
    chk(!wr_en, "R4 not same cycle", {63'b0, wr_en}, 64'h0);
    @(negedge clk); #0.5;
    chk(wr_en && wr_idx == 8'h20, "R4 next cycle", {55'b0, wr_en, wr_idx}, {55'b0, 1'b1, 8'h20});
    in_valid = 1'b0;
    @(negedge clk); #0.5;
    chk(!wr_en, "R4 single pulse", {63'b0, wr_en}, 64'h0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_operand = '0;
    in_cop_en = 1'b0; in_virt_en = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    t_reset();
    @(negedge clk);
    t_page();
    t_full();
    t_half();
    t_shared();
    t_counter();
    t_unimpl();
    t_cpu();
    t_ri();
    t_decode();
    t_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule